// File: doc/BRIEF.md
# Checksum-Gated Transmit Word Arbiter

This block decides which 32-bit word a serial slave port sends to its host next, and whether the device side may send anything beyond an identification word. Every packet the host sends arrives as a strobe with a 32-bit word: the top byte is the packet identifier and the low 24 bits are its payload. The block folds payloads into a running 24-bit XOR register. Device output is locked after reset and after any ordinary host packet. It is unlocked only when the host sends a checksum packet whose payload equals that register.

While locked, the block always offers the fixed identification word and keeps asking for a transfer. While unlocked, it picks by a fixed priority from a pending shutdown word, a pending roaming word, a 32-entry data queue, and finally the live status word. The status word is offered only to a transfer the host starts, so it raises no request. A transfer-complete strobe retires the source that was on offer. A write into a full queue flushes the queue and raises a sticky stop flag.

Top module: `spi_tx_gate`

## Requirements
- R1: After reset the checksum register holds 000308 hex, output is locked, no word is pending, the data queue is empty and `ovf_flag` is low.
- R2: A received packet whose identifier is not 00 and not in 1C..1F XORs its 24-bit payload into the checksum register. Packets with identifier 00 or 1C..1F leave the register unchanged. Accumulation continues while output is unlocked.
- R3: Any received packet whose identifier is not 00, including 1C..1F, locks output from the next cycle.
- R4: While locked, a packet with identifier 00 whose payload equals the register unlocks output from the next cycle. A non-equal payload leaves output locked and the register unchanged.
- R5: While unlocked, a packet with identifier 00 has no effect, whatever its payload.
- R6: While locked, `tx_word` is FF000308 hex, `tx_src` is 0 and `dev_req` is high.
- R7: While unlocked, the source is chosen in this order: pending shutdown word (`tx_src`=1), pending roaming word (2), queue head (3), and otherwise the live `stat_word` (4). `tx_word` carries the chosen word.
- R8: `dev_req` is high exactly when `tx_src` is not 4.
- R9: A pending word is cleared only by `xfer_done` while its source is on offer. A load in the same cycle keeps the word pending and takes the new data.
- R10: The data queue holds 32 words and returns them in write order. An entry is removed only by `xfer_done` while `tx_src` is 3.
- R11: A write to a full queue with no removal in the same cycle empties the queue and sets `ovf_flag`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Host packet received this cycle |
| rx_word | input | 32 | Received packet: identifier in [31:24], payload in [23:0] |
| xfer_done | input | 1 | The transfer of the offered word has completed |
| shut_load | input | 1 | Make the shutdown word pending |
| shut_word | input | 32 | Shutdown word data |
| roam_load | input | 1 | Make the roaming word pending |
| roam_word | input | 32 | Roaming word data |
| stat_word | input | 32 | Live status word |
| fifo_push | input | 1 | Write one word into the data queue |
| fifo_wdata | input | 32 | Data queue write word |
| tx_word | output | 32 | Word offered for the next transfer |
| tx_src | output | 3 | Source code of `tx_word` (0 id, 1 shutdown, 2 roaming, 3 queue, 4 status) |
| dev_req | output | 1 | Device requests a transfer |
| ovf_flag | output | 1 | Sticky queue overflow / stop flag |

## Verification
All state is registered and the outputs decode that state combinationally. The effect of any input sampled at one rising edge, such as a packet, a load, a queue write or a completion, therefore shows on the outputs in the cycle that follows, and not before. The bench drives inputs on the falling edge. Its behavioural model advances at the rising edge, and outputs are compared 3 ns after that edge. Directed checks read the outputs on the next falling edge after the stimulus, which is one full register stage later.

// File: rtl/spi_tx_gate_pkg.sv
package spi_tx_gate_pkg;

    localparam int ID_W   = 8;
    localparam int PAY_W  = 24;
    localparam int WORD_W = ID_W + PAY_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAY_W-1:0]  pay_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        pay_t            payload;
    } pkt_t;

    typedef enum logic [2:0] {
        SRC_PART = 3'd0,
        SRC_SHUT = 3'd1,
        SRC_ROAM = 3'd2,
        SRC_FIFO = 3'd3,
        SRC_STAT = 3'd4
    } src_e;

    localparam logic [ID_W-1:0] ID_CHECK   = 8'h00;
    localparam logic [ID_W-1:0] ID_SPEC_LO = 8'h1C;
    localparam logic [ID_W-1:0] ID_SPEC_HI = 8'h1F;

    function automatic logic is_check(input logic [ID_W-1:0] id);
        return id == ID_CHECK;
    endfunction

    function automatic logic skips_xor(input logic [ID_W-1:0] id);
        return (id == ID_CHECK) || (id >= ID_SPEC_LO && id <= ID_SPEC_HI);
    endfunction

endpackage

// File: rtl/xor_lock.sv
module xor_lock
    import spi_tx_gate_pkg::*;
#(
    parameter pay_t SEED = 24'h000308
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  pkt_t rx_pkt,
    output logic tx_en,
    output pay_t csum
);

    always_ff @(posedge clk) begin
        if (rst) begin
            csum  <= SEED;
            tx_en <= 1'b0;
        end else if (rx_valid) begin
            if (is_check(rx_pkt.id)) begin
                if (!tx_en && rx_pkt.payload == csum)
                    tx_en <= 1'b1;
            end else begin
                tx_en <= 1'b0;
                if (!skips_xor(rx_pkt.id))
                    csum <= csum ^ rx_pkt.payload;
            end
        end
    end

endmodule

// File: rtl/pend_slot.sv
module pend_slot
    import spi_tx_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t ldata,
    input  logic  clr,
    output logic  valid,
    output word_t data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= ldata;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/word_fifo.sv
module word_fifo
    import spi_tx_gate_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t wdata,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full,
    output logic  ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    word_t          mem [DEPTH];
    logic [AW-1:0]  rd_ptr, wr_ptr;
    logic [CW-1:0]  count;
    logic           pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULLC);
    assign pop_ok  = pop && !empty;
    assign ovf     = push && full && !pop_ok;
    assign push_ok = push && !ovf;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ovf) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/src_pick.sv
module src_pick
    import spi_tx_gate_pkg::*;
#(
    parameter word_t PART_ID = 32'hFF000308
) (
    input  logic  tx_en,
    input  logic  shut_v,
    input  word_t shut_d,
    input  logic  roam_v,
    input  word_t roam_d,
    input  logic  q_empty,
    input  word_t q_head,
    input  word_t stat_d,
    output src_e  sel,
    output word_t word
);

    always_comb begin
        if (!tx_en) begin
            sel  = SRC_PART;
            word = PART_ID;
        end else if (shut_v) begin
            sel  = SRC_SHUT;
            word = shut_d;
        end else if (roam_v) begin
            sel  = SRC_ROAM;
            word = roam_d;
        end else if (!q_empty) begin
            sel  = SRC_FIFO;
            word = q_head;
        end else begin
            sel  = SRC_STAT;
            word = stat_d;
        end
    end

endmodule

// File: rtl/spi_tx_gate.sv
module spi_tx_gate
    import spi_tx_gate_pkg::*;
#(
    parameter int    FIFO_DEPTH = 32,
    parameter word_t PART_ID    = 32'hFF000308
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [31:0] rx_word,
    input  logic        xfer_done,
    input  logic        shut_load,
    input  logic [31:0] shut_word,
    input  logic        roam_load,
    input  logic [31:0] roam_word,
    input  logic [31:0] stat_word,
    input  logic        fifo_push,
    input  logic [31:0] fifo_wdata,
    output logic [31:0] tx_word,
    output logic [2:0]  tx_src,
    output logic        dev_req,
    output logic        ovf_flag
);

    localparam int   N_SLOT = 2;
    localparam pay_t SEED   = PART_ID[PAY_W-1:0];

    logic  tx_en;
    pay_t  csum;
    src_e  sel;
    logic  f_empty, f_full, f_ovf, f_pop;
    word_t f_head;

    logic  slot_load [N_SLOT];
    word_t slot_in   [N_SLOT];
    logic  slot_clr  [N_SLOT];
    logic  slot_v    [N_SLOT];
    word_t slot_d    [N_SLOT];

    xor_lock #(.SEED(SEED)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_pkt   (pkt_t'(rx_word)),
        .tx_en    (tx_en),
        .csum     (csum)
    );

    assign slot_load[0] = shut_load;
    assign slot_in[0]   = shut_word;
    assign slot_clr[0]  = xfer_done && sel == SRC_SHUT;
    assign slot_load[1] = roam_load;
    assign slot_in[1]   = roam_word;
    assign slot_clr[1]  = xfer_done && sel == SRC_ROAM;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        pend_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .load  (slot_load[g]),
            .ldata (slot_in[g]),
            .clr   (slot_clr[g]),
            .valid (slot_v[g]),
            .data  (slot_d[g])
        );
    end

    assign f_pop = xfer_done && sel == SRC_FIFO;

    word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (f_pop),
        .head  (f_head),
        .empty (f_empty),
        .full  (f_full),
        .ovf   (f_ovf)
    );

    src_pick #(.PART_ID(PART_ID)) u_pick (
        .tx_en   (tx_en),
        .shut_v  (slot_v[0]),
        .shut_d  (slot_d[0]),
        .roam_v  (slot_v[1]),
        .roam_d  (slot_d[1]),
        .q_empty (f_empty),
        .q_head  (f_head),
        .stat_d  (stat_word),
        .sel     (sel),
        .word    (tx_word)
    );

    always_ff @(posedge clk) begin
        if (rst)        ovf_flag <= 1'b0;
        else if (f_ovf) ovf_flag <= 1'b1;
    end

    assign tx_src  = sel;
    assign dev_req = (sel != SRC_STAT);

endmodule

// File: rtl/spi_tx_gate_chk.sv
module spi_tx_gate_chk
    import spi_tx_gate_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic [31:0] rx_word,
    input logic        tx_en,
    input pay_t        csum,
    input logic        fifo_push,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        fifo_pop,
    input logic [2:0]  tx_src,
    input logic [31:0] tx_word,
    input logic        dev_req,
    input logic        ovf_flag
);

    assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_word[31:24] != 8'h00) |=> !tx_en);

    assert_bad_check_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_word[31:24] == 8'h00 && !tx_en && rx_word[23:0] != csum)
        |=> (!tx_en && $stable(csum)));

    assert_check_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_word[31:24] == 8'h00 && tx_en) |=> (tx_en && $stable(csum)));

    assert_locked_word_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (tx_src == 3'd0 && dev_req && tx_word == 32'hFF000308));

    assert_status_last_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_src == 3'd4) |-> (tx_en && fifo_empty));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && fifo_full && !fifo_pop) |=> (fifo_empty && ovf_flag));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

endmodule

bind spi_tx_gate spi_tx_gate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_word    (rx_word),
    .tx_en      (tx_en),
    .csum       (csum),
    .fifo_push  (fifo_push),
    .fifo_full  (f_full),
    .fifo_empty (f_empty),
    .fifo_pop   (f_pop),
    .tx_src     (tx_src),
    .tx_word    (tx_word),
    .dev_req    (dev_req),
    .ovf_flag   (ovf_flag)
);

// File: tb/spi_tx_gate_test.sv
module spi_tx_gate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        xfer_done = 1'b0;
    logic        shut_load = 1'b0;
    logic [31:0] shut_word = '0;
    logic        roam_load = 1'b0;
    logic [31:0] roam_word = '0;
    logic [31:0] stat_word = 32'h7F00_1234;
    logic        fifo_push = 1'b0;
    logic [31:0] fifo_wdata = '0;
    logic [31:0] tx_word;
    logic [2:0]  tx_src;
    logic        dev_req;
    logic        ovf_flag;

    always #5 clk = ~clk;

    spi_tx_gate uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // behavioural reference
    bit          m_en;
    logic [23:0] m_cs;
    bit          m_shv, m_rov, m_ovf;
    logic [31:0] m_shw, m_row;
    logic [31:0] m_q[$];

    function automatic int m_src();
        if (!m_en) return 0;
        if (m_shv) return 1;
        if (m_rov) return 2;
        if (m_q.size() != 0) return 3;
        return 4;
    endfunction

    function automatic logic [31:0] m_word();
        case (m_src())
            0: return 32'hFF000308;
            1: return m_shw;
            2: return m_row;
            3: return m_q[0];
            default: return stat_word;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_cs = 24'h000308; m_shv = 0; m_rov = 0; m_ovf = 0;
            m_q.delete();
        end else begin
            automatic int  s = m_src();
            automatic bit  popped = 0;
            if (xfer_done) begin
                if (s == 1) m_shv = 0;
                if (s == 2) m_rov = 0;
                if (s == 3) begin void'(m_q.pop_front()); popped = 1; end
            end
            if (rx_valid) begin
                if (rx_word[31:24] == 8'h00) begin
                    if (!m_en && rx_word[23:0] == m_cs) m_en = 1;
                end else begin
                    m_en = 0;
                    if (!(rx_word[31:24] >= 8'h1C && rx_word[31:24] <= 8'h1F))
                        m_cs = m_cs ^ rx_word[23:0];
                end
            end
            if (shut_load) begin m_shv = 1; m_shw = shut_word; end
            if (roam_load) begin m_rov = 1; m_row = roam_word; end
            if (fifo_push) begin
                if (m_q.size() == 32 && !popped) begin
                    m_q.delete(); m_ovf = 1;
                end else m_q.push_back(fifo_wdata);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            automatic int es = m_src();
            chk(tx_src == 3'(es), (es == 0) ? "R6 src" : "R7 src", 32'(tx_src), 32'(es));
            if (tx_src == 3'(es))
                chk(tx_word == m_word(), (es == 3) ? "R10 word" : "R7 word", tx_word, m_word());
            chk(dev_req == (es != 4), "R8 req", 32'(dev_req), 32'(es != 4));
            chk(ovf_flag == m_ovf, "R11 ovf", 32'(ovf_flag), 32'(m_ovf));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic send(input logic [31:0] w);
        @(negedge clk); rx_valid = 1; rx_word = w;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic done_x();
        @(negedge clk); xfer_done = 1;
        @(negedge clk); xfer_done = 0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); fifo_push = 1; fifo_wdata = w;
        @(negedge clk); fifo_push = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(tx_src == 3'd0, "R1 locked", 32'(tx_src), 0);
        chk(tx_word == 32'hFF000308, "R6 id word", tx_word, 32'hFF000308);
        chk(dev_req && !ovf_flag, "R1 req/ovf", {dev_req, ovf_flag}, 32'h2);

        send(32'h01_123456);
        send(32'h10_00FF00);              // register now 12C85E
        send(32'h00_000000);
        chk(tx_src == 3'd0, "R4 mismatch stays locked", 32'(tx_src), 0);
        send(32'h1C_ABCDEF);              // exempt: register unchanged
        send(32'h00_12C85E);
        chk(tx_src == 3'd4, "R2 R4 unlock", 32'(tx_src), 4);
        chk(tx_word == stat_word && !dev_req, "R8 status no req", tx_word, stat_word);
        send(32'h00_FFFFFF);
        chk(tx_src == 3'd4, "R5 check ignored", 32'(tx_src), 4);

        push(32'hA0A0_0001); push(32'hA0A0_0002); push(32'hA0A0_0003);
        @(negedge clk); roam_load = 1; roam_word = 32'h6000_0077; shut_load = 1; shut_word = 32'h7E00_0055;
        @(negedge clk); roam_load = 0; shut_load = 0;
        chk(tx_src == 3'd1 && tx_word == 32'h7E00_0055, "R7 shut first", tx_word, 32'h7E00_0055);
        @(negedge clk);
        chk(tx_src == 3'd1, "R9 held until done", 32'(tx_src), 1);
        done_x();
        chk(tx_src == 3'd2 && tx_word == 32'h6000_0077, "R9 R7 roam next", tx_word, 32'h6000_0077);
        done_x();
        chk(tx_word == 32'hA0A0_0001, "R10 head", tx_word, 32'hA0A0_0001);
        done_x();
        chk(tx_word == 32'hA0A0_0002, "R10 order", tx_word, 32'hA0A0_0002);

        send(32'h05_000001);
        chk(tx_src == 3'd0, "R3 relock", 32'(tx_src), 0);
        send(32'h00_12C85F);
        chk(tx_src == 3'd3, "R2 accumulate after unlock", 32'(tx_src), 3);

        for (int i = 0; i < 30; i++) push(32'hB000_0000 + 32'(i));
        chk(!ovf_flag && tx_word == 32'hA0A0_0002, "R10 full no ovf", 32'(ovf_flag), 0);
        push(32'hCCCC_CCCC);
        chk(ovf_flag && tx_src == 3'd4, "R11 flush", {ovf_flag, tx_src}, 32'hC);

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            rx_valid  = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 4))
                0: rx_word = {8'h00, m_cs};
                1: rx_word = {8'h00, 24'($urandom)};
                2: rx_word = {8'(8'h1C + $urandom_range(0, 3)), 24'($urandom)};
                default: rx_word = {8'($urandom_range(1, 255)), 24'($urandom)};
            endcase
            xfer_done  = ($urandom_range(0, 2) == 0);
            shut_load  = ($urandom_range(0, 15) == 0);
            shut_word  = $urandom;
            roam_load  = ($urandom_range(0, 11) == 0);
            roam_word  = $urandom;
            fifo_push  = ($urandom_range(0, 2) == 0);
            fifo_wdata = $urandom;
            stat_word  = $urandom;
        end
        @(negedge clk);
        rx_valid = 0; xfer_done = 0; shut_load = 0; roam_load = 0; fifo_push = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule